// File: doc/BRIEF.md
# Rotor Substitution Cipher Engine

This block enciphers letters of a 26-symbol alphabet, coded as binary 0 to 25, through a cascade of loadable substitution stages. A letter enters through a swap table that an operator can load. It then runs through three offset rotor substitutions and a fixed pairing reflector. It comes back through the three rotors in inverse form and passes the swap table a second time. All tables are written through a small configuration port before use. The start position of each rotor is loaded through the same port.

The rotor positions change with every accepted letter, in the way an odometer counts. The fast rotor moves first. Its wrap from 25 to 0 carries into the middle rotor, and the middle rotor's wrap carries into the slow rotor. The reflector has no fixed points and the path is symmetric, so when the swap table is an involution the same operation deciphers. Feeding the ciphertext back in from the same start positions gives the plaintext.

Top module: `rotor_cipher_engine`

## Requirements
- R1: Letters on `in_letter` and `out_letter` are unsigned binary codes 0 to 25. A delivered `out_letter` is always below 26.
- R2: When idle, `in_ready` is high. An accepted letter (`in_valid` and `in_ready` high at a rising edge) drops `in_ready` for one cycle. The result is delivered with `out_valid` high for exactly one cycle, in the second cycle after the accepting edge.
- R3: Every accepted letter advances rotor 0 by one position, modulo 26, before that letter is enciphered.
- R4: When rotor 0 wraps from 25 to 0, rotor 1 advances by one. When rotor 1 wraps in that same step, rotor 2 advances by one. Otherwise rotors 1 and 2 hold.
- R5: With swap table S, rotor wirings W0..W2 at positions P0..P2 and the reflector F, the result is S(b0). Here f0 = S(x). Each f(k+1) = (Wk((fk+Pk) mod 26) − Pk) mod 26. Then b3 = F(f3), each bk = (Wk⁻¹((b(k+1)+Pk) mod 26) − Pk) mod 26.
- R6: The reflector F pairs each even code 2n with 2n+1. With an involutive swap table, enciphering the ciphertext again from the same start positions restores the plaintext.
- R7: Configuration writes use `cfg_tgt`. Targets 0, 1 and 2 write rotor k's wiring, taking input contact `cfg_addr` to output `cfg_data`. Target 3 writes swap entry `cfg_addr` → `cfg_data`. Target 4 writes the start position of rotor `cfg_addr`. A start write also sets that rotor's current position at once.
- R8: A configuration write is dropped while a letter is in flight (`in_ready` low). It is also dropped in the same cycle a letter is accepted.
- R9: A synchronous active-high reset clears `out_valid` and `out_letter` and raises `in_ready`. It returns every rotor position to its loaded start value. The loaded tables and start values are kept.
- R10: With permutation wirings and an involutive swap table, no letter enciphers to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input letter offered |
| in_ready | output | 1 | Engine can accept a letter |
| in_letter | input | 5 | Plain letter code 0..25 |
| out_valid | output | 1 | One-cycle strobe for a ciphered letter |
| out_letter | output | 5 | Ciphered letter code 0..25 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tgt | input | 3 | Write target: rotor 0..2, swap table 3, start position 4 |
| cfg_addr | input | 5 | Entry index or rotor number |
| cfg_data | input | 5 | Value written |

## Verification
A configuration write and a letter acceptance can arrive in the same cycle. A write can also land one cycle later, while the accepted letter is still in flight. The bench provokes both by asserting `cfg_we` alongside `in_valid`, and again one cycle after acceptance. In each case it rewrites rotor 0's start position to 10. The next letter is judged against a model whose rotor positions never saw that write, so any leak shows up as a changed ciphertext.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;
    localparam int ALPHA = 26;
    localparam int LW    = 5;
    localparam int DEPTH = 1 << LW;

    typedef logic [LW-1:0] letter_t;

    localparam logic [LW:0] ALPHA_X = (LW+1)'(ALPHA);
    localparam letter_t     LAST    = letter_t'(ALPHA - 1);

    typedef struct packed {
        logic    vld;
        letter_t ltr;
    } stage_t;

    function automatic letter_t mod_add(letter_t a, letter_t b);
        logic [LW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= ALPHA_X) s = s - ALPHA_X;
        return s[LW-1:0];
    endfunction

    function automatic letter_t mod_sub(letter_t a, letter_t b);
        logic [LW:0] s;
        s = {1'b0, a} + ALPHA_X - {1'b0, b};
        if (s >= ALPHA_X) s = s - ALPHA_X;
        return s[LW-1:0];
    endfunction

    // pairs 2n with 2n+1: an involution with no fixed point
    function automatic letter_t reflect(letter_t a);
        return {a[LW-1:1], ~a[0]};
    endfunction

    function automatic letter_t bump(letter_t a);
        return (a == LAST) ? '0 : a + letter_t'(1);
    endfunction
endpackage

// File: rtl/rc_rotor.sv
`timescale 1ns/1ps
module rc_rotor
    import rc_pkg::*;
(
    input  logic    clk,
    input  logic    we,
    input  letter_t waddr,
    input  letter_t wdata,
    input  letter_t pos,
    input  letter_t f_in,
    output letter_t f_out,
    input  letter_t b_in,
    output letter_t b_out
);
    letter_t fwd_tab [DEPTH];
    letter_t inv_tab [DEPTH];

    // the inverse table is filled alongside, so both directions are one lookup
    always_ff @(posedge clk) begin
        if (we) begin
            fwd_tab[waddr] <= wdata;
            inv_tab[wdata] <= waddr;
        end
    end

    always_comb begin
        f_out = mod_sub(fwd_tab[mod_add(f_in, pos)], pos);
        b_out = mod_sub(inv_tab[mod_add(b_in, pos)], pos);
    end
endmodule

// File: rtl/rc_plug.sv
`timescale 1ns/1ps
module rc_plug
    import rc_pkg::*;
(
    input  logic    clk,
    input  logic    we,
    input  letter_t waddr,
    input  letter_t wdata,
    input  letter_t a_in,
    output letter_t a_out,
    input  letter_t b_in,
    output letter_t b_out
);
    letter_t swap_tab [DEPTH];

    always_ff @(posedge clk) begin
        if (we) swap_tab[waddr] <= wdata;
    end

    assign a_out = swap_tab[a_in];
    assign b_out = swap_tab[b_in];
endmodule

// File: rtl/rc_stepper.sv
`timescale 1ns/1ps
module rc_stepper
    import rc_pkg::*;
#(
    parameter int NR = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             ld_en,
    input  letter_t          ld_idx,
    input  letter_t          ld_val,
    output letter_t [NR-1:0] pos
);
    letter_t [NR-1:0] start_q;
    letter_t [NR-1:0] pos_q;
    logic    [NR-1:0] carry;
    logic    [NR-1:0] ld_hit;

    for (genvar i = 0; i < NR; i++) begin : g_wheel
        if (i == 0) begin : g_fast
            assign carry[i] = step;
        end else begin : g_slow
            assign carry[i] = carry[i-1] && (pos_q[i-1] == LAST);
        end
        assign ld_hit[i] = ld_en && (ld_idx == letter_t'(i));

        always_ff @(posedge clk) begin
            if (ld_hit[i]) start_q[i] <= ld_val;
        end

        always_ff @(posedge clk) begin
            if (rst)            pos_q[i] <= start_q[i];
            else if (carry[i])  pos_q[i] <= bump(pos_q[i]);
            else if (ld_hit[i]) pos_q[i] <= ld_val;
        end
    end

    assign pos = pos_q;

    AST_FAST_STEP: assert property (@(posedge clk) disable iff (rst)
        step && pos_q[0] != LAST |=> pos_q[0] == $past(pos_q[0]) + letter_t'(1)); // R3
    AST_FAST_WRAP: assert property (@(posedge clk) disable iff (rst)
        step && pos_q[0] == LAST |=> pos_q[0] == '0); // R4
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step && !ld_en |=> $stable(pos_q)); // R8
    if (NR > 1) begin : g_chk_slow
        AST_NO_EARLY_CARRY: assert property (@(posedge clk) disable iff (rst)
            step && pos_q[0] != LAST |=> $stable(pos_q[NR-1:1])); // R4
    end
endmodule

// File: rtl/rotor_cipher_engine.sv
`timescale 1ns/1ps
module rotor_cipher_engine
    import rc_pkg::*;
#(
    parameter  int N_ROT = 3,
    localparam int TGT_W = $clog2(N_ROT + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [LW-1:0]    in_letter,
    output logic             out_valid,
    output logic [LW-1:0]    out_letter,
    input  logic             cfg_we,
    input  logic [TGT_W-1:0] cfg_tgt,
    input  logic [LW-1:0]    cfg_addr,
    input  logic [LW-1:0]    cfg_data
);
    stage_t              stg_q;
    logic                accept;
    logic                cfg_ok;
    letter_t [N_ROT-1:0] pos;
    letter_t             fwd [N_ROT+1];
    letter_t             bwd [N_ROT+1];
    letter_t             res;

    assign in_ready = ~stg_q.vld;
    assign accept   = in_valid & in_ready;
    // letter traffic wins any collision with a table write
    assign cfg_ok   = cfg_we & ~accept & ~stg_q.vld;

    always_ff @(posedge clk) begin
        if (rst)         stg_q <= '0;
        else if (accept) stg_q <= '{vld: 1'b1, ltr: in_letter};
        else             stg_q.vld <= 1'b0;
    end

    rc_stepper #(.NR(N_ROT)) i_stepper (
        .clk    (clk),
        .rst    (rst),
        .step   (accept),
        .ld_en  (cfg_ok && cfg_tgt == TGT_W'(N_ROT + 1)),
        .ld_idx (cfg_addr),
        .ld_val (cfg_data),
        .pos    (pos)
    );

    rc_plug i_plug (
        .clk   (clk),
        .we    (cfg_ok && cfg_tgt == TGT_W'(N_ROT)),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .a_in  (stg_q.ltr),
        .a_out (fwd[0]),
        .b_in  (bwd[0]),
        .b_out (res)
    );

    for (genvar k = 0; k < N_ROT; k++) begin : g_rotor
        rc_rotor i_rotor (
            .clk   (clk),
            .we    (cfg_ok && cfg_tgt == TGT_W'(k)),
            .waddr (cfg_addr),
            .wdata (cfg_data),
            .pos   (pos[k]),
            .f_in  (fwd[k]),
            .f_out (fwd[k+1]),
            .b_in  (bwd[k+1]),
            .b_out (bwd[k])
        );
    end

    assign bwd[N_ROT] = reflect(fwd[N_ROT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_letter <= '0;
        end else begin
            out_valid <= stg_q.vld;
            if (stg_q.vld) out_letter <= res;
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##2 out_valid); // R2
    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R2
    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_letter <= LAST); // R1
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && in_ready); // R9
endmodule

// File: tb/test_rotor_cipher_engine.sv
`timescale 1ns/1ps
module test_rotor_cipher_engine;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_ready;
    logic [4:0] in_letter;
    logic       out_valid;
    logic [4:0] out_letter;
    logic       cfg_we;
    logic [2:0] cfg_tgt;
    logic [4:0] cfg_addr;
    logic [4:0] cfg_data;

    always #2.5 clk = ~clk;

    rotor_cipher_engine i_rotor_cipher_engine (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_letter(in_letter), .out_valid(out_valid), .out_letter(out_letter),
        .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
    );

    localparam int NV = 24;
    localparam int PLAIN [NV] = '{0, 25, 7, 7, 12, 3, 19, 1, 24, 13, 5, 20,
                                  8, 0, 16, 11, 22, 2, 9, 14, 25, 6, 17, 4};

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    int mult [3] = '{5, 7, 11};
    int offs [3] = '{3, 11, 2};
    int pl   [26];
    int p    [3];
    int st   [3];
    int ct   [NV];

    function automatic int wire_f(int k, int x);
        return (mult[k] * x + offs[k]) % 26;
    endfunction

    function automatic int wire_inv(int k, int y);
        for (int x = 0; x < 26; x++) if (wire_f(k, x) == y) return x;
        return 0;
    endfunction

    function automatic int model_cipher(int x);
        int y;
        y = pl[x];
        for (int k = 0; k < 3; k++) y = (wire_f(k, (y + p[k]) % 26) + 26 - p[k]) % 26;
        y = y ^ 1;
        for (int k = 2; k >= 0; k--) y = (wire_inv(k, (y + p[k]) % 26) + 26 - p[k]) % 26;
        return pl[y];
    endfunction

    task automatic model_step();
        p[0] = p[0] + 1;
        if (p[0] == 26) begin
            p[0] = 0;
            p[1] = p[1] + 1;
            if (p[1] == 26) begin
                p[1] = 0;
                p[2] = (p[2] + 1) % 26;
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic cfg_write(input int tgt, input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tgt = 3'(tgt); cfg_addr = 5'(addr); cfg_data = 5'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // coll: 0 none, 1 write with acceptance, 2 write while in flight
    task automatic send(input int ltr, input int coll, input string tag, output int got);
        int exp_v;
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready when idle", int'(in_ready), 1);
        in_valid = 1'b1; in_letter = 5'(ltr);
        if (coll == 1) begin
            cfg_we = 1'b1; cfg_tgt = 3'd4; cfg_addr = 5'd0; cfg_data = 5'd10;
        end
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        model_step();
        exp_v = model_cipher(ltr);
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R2 busy after accept", int'(in_ready), 0);
        if (coll == 2) begin
            cfg_we = 1'b1; cfg_tgt = 3'd4; cfg_addr = 5'd0; cfg_data = 5'd10;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        got = int'(out_letter);
        chk(out_valid == 1'b1, "R2 result strobe", int'(out_valid), 1);
        chk(got == exp_v, tag, got, exp_v);
        chk(got < 26, "R1 output range", got, 25);
        chk(got != ltr, "R10 no self-encipher", got, ltr);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 single-cycle strobe", int'(out_valid), 0);
    endtask

    task automatic load_rotor(input int k);
        for (int x = 0; x < 26; x++) cfg_write(k, x, wire_f(k, x));
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 idle after reset", int'(out_valid), 0);
        for (int k = 0; k < 3; k++) p[k] = st[k];
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int got;
        rst = 1'b1; in_valid = 1'b0; in_letter = '0;
        cfg_we = 1'b0; cfg_tgt = '0; cfg_addr = '0; cfg_data = '0;
        for (int i = 0; i < 26; i++) pl[i] = i;
        pl[0] = 7;  pl[7] = 0;  pl[3] = 12; pl[12] = 3; pl[5] = 20; pl[20] = 5;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
        chk(out_letter == 5'd0, "R9 reset out_letter", int'(out_letter), 0);
        rst = 1'b0;

        // R7 table and start loads; start 23/25/4 forces a double carry on letter 3
        for (int k = 0; k < 3; k++) load_rotor(k);
        for (int i = 0; i < 26; i++) cfg_write(3, i, pl[i]);
        st = '{23, 25, 4};
        for (int k = 0; k < 3; k++) cfg_write(4, k, st[k]);
        for (int k = 0; k < 3; k++) p[k] = st[k];

        // R3/R4/R5 vector walk
        for (int i = 0; i < NV; i++) begin
            send(PLAIN[i], 0, "R3/R4/R5 cipher vector", got);
            ct[i] = got;
        end

        // R9 reset restores start positions, R6 reciprocity
        pulse_reset();
        for (int i = 0; i < NV; i++) begin
            send(ct[i], 0, "R6 decipher path", got);
            chk(got == PLAIN[i], "R6 plaintext restored", got, PLAIN[i]);
        end

        // R8 write in the acceptance cycle, then a write while in flight
        send(7, 1, "R8 same-cycle letter", got);
        send(8, 0, "R8 same-cycle write dropped", got);
        send(9, 2, "R8 in-flight letter", got);
        send(10, 0, "R8 in-flight write dropped", got);

        // R7 start write takes effect at once, rotor rewire is honoured
        st = '{0, 0, 0};
        for (int k = 0; k < 3; k++) cfg_write(4, k, 0);
        for (int k = 0; k < 3; k++) p[k] = 0;
        send(4, 0, "R7 start position load", got);
        mult[1] = 3; offs[1] = 5;
        load_rotor(1);
        send(4, 0, "R7 rewired rotor", got);
        send(21, 0, "R7 rewired rotor", got);

        // R9 reset mid-stream
        pulse_reset();
        send(13, 0, "R9 positions back at start", got);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule